// File: doc/BRIEF.md
# Matrix LCD Row Scan Controller

This block keeps a small monochrome matrix display refreshed over a serial shift-register link without help from software. A two-stage prescaler divides a reference enable down to a base tick. A line timer then produces a periodic line latch pulse (`lp`). After each latch pulse falls and a short fixed delay passes, the block selects the next row. It reads that row from a synchronous frame buffer, one byte per read, and shifts its bits out on `sdata` under the shift clock `scp`. The whole row is out well before the next latch pulse.

The rows are scanned in ascending order and wrap after the last row. When the scan wraps to row 0, the first-line marker `flm` goes high. It stays high through the whole row-0 line and through the following latch pulse. It is cleared at the same delayed point after that pulse falls, and that point is re-evaluated after every latch pulse. The shift clock's idle level and its sampling edge are selected by parameters. The frame buffer is read at address `row * BYTES + byte`, with one clock of read latency. The next byte is fetched while the current byte shifts, so no gap appears between bytes.

Top module: `lcd_row_scan`

## Requirements
- R1: Stage 1 counts `ref_en` pulses modulo PRE1, and stage 2 counts stage-1 terminal counts modulo PRE2. A divide of 1 passes the input straight through. `lp` rises once every LINE_TICKS base ticks.
- R2: `lp` stays high for exactly one base-tick interval, the number of clocks between two consecutive base ticks.
- R3: During reset, `lp`, `flm`, `sdata` and `fb_rd_en` are 0, and `scp` sits at the level SCP_IDLE.
- R4: Each line sends BYTES*8 bits. Byte index 0 goes first and each byte goes most significant bit first. A bit is taken as the value of `sdata` at the sampling edge of `scp`.
- R5: Exactly BYTES*8 sampling edges occur between a falling edge of `lp` and the next rising edge of `lp`.
- R6: The line started after the k-th falling edge of `lp` since reset (k counted from 0) carries row k mod ROWS. `flm` is 1 throughout exactly those lines that carry row 0, up to and including the following `lp` pulse.
- R7: `flm` changes only FLM_DLY+1 clocks after `lp` falls, and it is re-evaluated after every `lp` pulse. It never changes while `lp` is high.
- R8: For each line, the block issues BYTES reads. They are single-cycle `fb_rd_en` strobes at addresses `row*BYTES + 0`, `+1`, and so on in order. `fb_rd_data` is taken one clock after the strobe.
- R9: `scp` idles at SCP_IDLE. With CPHA=0, data is set up before the leading edge, which is the sampling edge. With CPHA=1, data changes on the leading edge and is sampled on the trailing edge. `sdata` never changes on a sampling edge, and `scp` is at its idle level while `lp` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_en | input | 1 | Reference enable, one pulse per reference period |
| fb_rd_data | input | 8 | Frame-buffer read data, valid one clock after the strobe |
| lp | output | 1 | Line latch pulse |
| flm | output | 1 | First-line marker |
| scp | output | 1 | Shift clock |
| sdata | output | 1 | Serial row data |
| fb_rd_en | output | 1 | Frame-buffer read strobe |
| fb_rd_addr | output | AW | Frame-buffer byte address, row*BYTES + byte index |

## Verification
A wrong row counter or wrong address arithmetic shows up on the first affected line. It appears as a wrong read address and wrong bits at the sampling edges, and is caught at the next rising edge of `lp`. A fault in the shifter's bit or byte counting shows up as a wrong number of sampling edges before `lp` rises, or as data moving on a sampling edge. A prescaler or line-timer fault shows up as a wrong `lp` width or period within one line. A fault in the FLM delay or the wrap detection shows up within FLM_DLY+1 clocks of an `lp` falling edge.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

   typedef enum logic [1:0] {
      SH_IDLE = 2'd0,
      SH_WAIT = 2'd1,
      SH_RUN  = 2'd2
   } shift_st_t;

   function automatic int clog2_min1(input int v);
      return (v <= 2) ? 1 : $clog2(v);
   endfunction

endpackage

// File: rtl/lcd_line_timer.sv
module lcd_line_timer #(
   parameter int PRE1       = 16,
   parameter int PRE2       = 15,
   parameter int LINE_TICKS = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_en,
   output logic lp
);
   import lcd_scan_pkg::*;

   localparam int LTW = clog2_min1(LINE_TICKS);

   logic stage1_tc;
   logic base_tick;

   generate
      if (PRE1 == 1) begin : g_s1_pass
         assign stage1_tc = ref_en;
      end else begin : g_s1_div
         localparam int W1 = clog2_min1(PRE1);
         logic [W1-1:0] cnt1;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt1 <= '0;
            else if (ref_en) cnt1 <= (cnt1 == W1'(PRE1-1)) ? '0 : cnt1 + 1'b1;
         end
         assign stage1_tc = ref_en && (cnt1 == W1'(PRE1-1));
      end

      if (PRE2 == 1) begin : g_s2_pass
         assign base_tick = stage1_tc;
      end else begin : g_s2_div
         localparam int W2 = clog2_min1(PRE2);
         logic [W2-1:0] cnt2;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt2 <= '0;
            else if (stage1_tc) cnt2 <= (cnt2 == W2'(PRE2-1)) ? '0 : cnt2 + 1'b1;
         end
         assign base_tick = stage1_tc && (cnt2 == W2'(PRE2-1));
      end
   endgenerate

   logic [LTW-1:0] line_cnt;
   logic           lp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_cnt <= '0;
         lp_q     <= 1'b0;
      end else if (base_tick) begin
         line_cnt <= (line_cnt == LTW'(LINE_TICKS-1)) ? '0 : line_cnt + 1'b1;
         lp_q     <= (line_cnt == LTW'(LINE_TICKS-2));
      end
   end

   assign lp = lp_q;

endmodule

// File: rtl/lcd_line_seq.sv
module lcd_line_seq #(
   parameter int ROWS    = 24,
   parameter int FLM_DLY = 20,
   parameter int RW      = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          lp,
   output logic          start,
   output logic [RW-1:0] row_next,
   output logic          flm
);
   import lcd_scan_pkg::*;

   localparam int DW = clog2_min1(FLM_DLY+1);

   logic          lp_d;
   logic          dly_on;
   logic [DW-1:0] dly_cnt;
   logic [RW-1:0] row_q;
   logic          flm_q;
   logic          wrap;

   assign wrap     = (row_q == RW'(ROWS-1));
   assign row_next = wrap ? '0 : row_q + 1'b1;
   assign start    = dly_on && (dly_cnt == DW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lp_d    <= 1'b0;
         dly_on  <= 1'b0;
         dly_cnt <= '0;
         row_q   <= RW'(ROWS-1);
         flm_q   <= 1'b0;
      end else begin
         lp_d <= lp;
         if (lp_d && !lp) begin
            dly_on  <= 1'b1;
            dly_cnt <= DW'(FLM_DLY);
         end else if (dly_on) begin
            if (dly_cnt == DW'(1)) dly_on <= 1'b0;
            else dly_cnt <= dly_cnt - 1'b1;
         end
         if (start) begin
            row_q <= row_next;
            flm_q <= wrap;
         end
      end
   end

   assign flm = flm_q;

endmodule

// File: rtl/lcd_row_shifter.sv
module lcd_row_shifter #(
   parameter int BYTES    = 5,
   parameter int SCP_HALF = 4,
   parameter bit SCP_IDLE = 1'b0,
   parameter bit CPHA     = 1'b0,
   parameter int RW       = 5,
   parameter int AW       = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [RW-1:0] row_idx,
   output logic          rd_en,
   output logic [AW-1:0] rd_addr,
   input  logic [7:0]    rd_data,
   output logic          scp,
   output logic          sdata
);
   import lcd_scan_pkg::*;

   localparam int BCW = clog2_min1(BYTES+1);
   localparam int HCW = clog2_min1(SCP_HALF);

   shift_st_t      st;
   logic           rd_en_q, rd_vld_q;
   logic [AW-1:0]  rd_addr_q, base_q;
   logic [7:0]     hold_q, sreg_q;
   logic           hold_v;
   logic [HCW-1:0] hcnt;
   logic           ph;
   logic [2:0]     bitc;
   logic [BCW-1:0] loaded, fetched;

   logic half_end, byte_end, do_load, finish;

   assign half_end = (hcnt == HCW'(SCP_HALF-1));
   assign byte_end = (st == SH_RUN) && half_end && ph && (bitc == 3'd0);
   assign do_load  = ((st == SH_WAIT) && hold_v) || (byte_end && (loaded != BCW'(BYTES)));
   assign finish   = byte_end && (loaded == BCW'(BYTES));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= SH_IDLE;
         rd_en_q   <= 1'b0;
         rd_vld_q  <= 1'b0;
         rd_addr_q <= '0;
         base_q    <= '0;
         hold_q    <= '0;
         hold_v    <= 1'b0;
         sreg_q    <= '0;
         hcnt      <= '0;
         ph        <= 1'b0;
         bitc      <= '0;
         loaded    <= '0;
         fetched   <= '0;
      end else begin
         rd_en_q  <= 1'b0;
         rd_vld_q <= rd_en_q;
         if (rd_vld_q) begin
            hold_q <= rd_data;
            hold_v <= 1'b1;
         end
         if (start) begin
            st        <= SH_WAIT;
            base_q    <= AW'(int'(row_idx) * BYTES);
            rd_addr_q <= AW'(int'(row_idx) * BYTES);
            rd_en_q   <= 1'b1;
            fetched   <= BCW'(1);
            loaded    <= '0;
            hold_v    <= 1'b0;
         end else if (do_load) begin
            sreg_q <= hold_q;
            hold_v <= 1'b0;
            loaded <= loaded + 1'b1;
            st     <= SH_RUN;
            ph     <= 1'b0;
            hcnt   <= '0;
            bitc   <= 3'd7;
            if (fetched != BCW'(BYTES)) begin
               rd_en_q   <= 1'b1;
               rd_addr_q <= base_q + AW'(fetched);
               fetched   <= fetched + 1'b1;
            end
         end else if (finish) begin
            st <= SH_IDLE;
         end else if (st == SH_RUN) begin
            if (half_end) begin
               hcnt <= '0;
               if (!ph) begin
                  ph <= 1'b1;
               end else begin
                  ph     <= 1'b0;
                  bitc   <= bitc - 1'b1;
                  sreg_q <= {sreg_q[6:0], 1'b0};
               end
            end else begin
               hcnt <= hcnt + 1'b1;
            end
         end
      end
   end

   assign rd_en   = rd_en_q;
   assign rd_addr = rd_addr_q;
   assign sdata   = (st == SH_RUN) && sreg_q[7];

   generate
      if (CPHA) begin : g_late_sample
         assign scp = SCP_IDLE ^ ((st == SH_RUN) && !ph);
      end else begin : g_early_sample
         assign scp = SCP_IDLE ^ ((st == SH_RUN) && ph);
      end
   endgenerate

endmodule

// File: rtl/lcd_row_scan.sv
module lcd_row_scan
   import lcd_scan_pkg::*;
#(
   parameter int PRE1       = 16,
   parameter int PRE2       = 15,
   parameter int LINE_TICKS = 100,
   parameter int ROWS       = 24,
   parameter int BYTES      = 5,
   parameter int SCP_HALF   = 4,
   parameter bit SCP_IDLE   = 1'b0,
   parameter bit CPHA       = 1'b0,
   parameter int FLM_DLY    = 20,
   localparam int AW        = clog2_min1(ROWS*BYTES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ref_en,
   input  logic [7:0]    fb_rd_data,
   output logic          lp,
   output logic          flm,
   output logic          scp,
   output logic          sdata,
   output logic          fb_rd_en,
   output logic [AW-1:0] fb_rd_addr
);

   localparam int RW        = clog2_min1(ROWS);
   localparam int BITS      = BYTES * 8;
   localparam int MIN_LINE  = PRE1 * PRE2 * (LINE_TICKS - 1);
   localparam int NEED_LINE = 2 * SCP_HALF * BITS + FLM_DLY + 8;

   generate
      if (PRE1 < 1 || PRE1 > 16 || PRE2 < 1 || PRE2 > 16) begin : g_bad_div
         $error("lcd_row_scan: prescaler stages accept 1 to 16");
      end
      if (LINE_TICKS < 2 || ROWS < 2 || BYTES < 1 || SCP_HALF < 1 || FLM_DLY < 1) begin : g_bad_geom
         $error("lcd_row_scan: line, row, byte, half-period or delay setting too small");
      end
      if (MIN_LINE < NEED_LINE) begin : g_bad_fit
         $error("lcd_row_scan: a row does not fit inside one line period");
      end
   endgenerate

   logic          start;
   logic [RW-1:0] row_next;

   lcd_line_timer #(
      .PRE1(PRE1), .PRE2(PRE2), .LINE_TICKS(LINE_TICKS)
   ) u_timer (
      .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .lp(lp)
   );

   lcd_line_seq #(
      .ROWS(ROWS), .FLM_DLY(FLM_DLY), .RW(RW)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .lp(lp),
      .start(start), .row_next(row_next), .flm(flm)
   );

   lcd_row_shifter #(
      .BYTES(BYTES), .SCP_HALF(SCP_HALF), .SCP_IDLE(SCP_IDLE),
      .CPHA(CPHA), .RW(RW), .AW(AW)
   ) u_shift (
      .clk(clk), .rst_n(rst_n), .start(start), .row_idx(row_next),
      .rd_en(fb_rd_en), .rd_addr(fb_rd_addr), .rd_data(fb_rd_data),
      .scp(scp), .sdata(sdata)
   );

endmodule

// File: rtl/lcd_row_scan_chk.sv
module lcd_row_scan_chk #(
   parameter int ROWS     = 24,
   parameter int BYTES    = 5,
   parameter bit SCP_IDLE = 1'b0,
   parameter bit CPHA     = 1'b0,
   parameter int AW       = 7
) (
   input logic          clk,
   input logic          rst_n,
   input logic          lp,
   input logic          flm,
   input logic          scp,
   input logic          sdata,
   input logic          fb_rd_en,
   input logic [AW-1:0] fb_rd_addr
);
   localparam int BITS = BYTES * 8;
   localparam bit SAMP = CPHA ? SCP_IDLE : ~SCP_IDLE;

   logic lp_q, scp_q;
   int   edge_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lp_q     <= 1'b0;
         scp_q    <= SCP_IDLE;
         edge_cnt <= 0;
      end else begin
         lp_q  <= lp;
         scp_q <= scp;
         if (lp_q && !lp) edge_cnt <= 0;
         else if (scp == SAMP && scp_q != SAMP) edge_cnt <= edge_cnt + 1;
      end
   end

   // R5: a line holds either no bits (before the first line) or a full row at the next latch
   a_r5_row_complete: assert property (@(posedge clk) disable iff (!rst_n)
      (lp && !lp_q) |-> (edge_cnt == 0 || edge_cnt == BITS));

   // R7: the first-line marker never moves while the latch pulse is high
   a_r7_flm_quiet_in_lp: assert property (@(posedge clk) disable iff (!rst_n)
      (lp && lp_q) |-> $stable(flm));

   // R8: every read stays inside the frame
   a_r8_addr_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
      fb_rd_en |-> (int'(fb_rd_addr) < ROWS * BYTES));

   // R9: data holds across the sampling edge
   a_r9_data_stable_at_sample: assert property (@(posedge clk) disable iff (!rst_n)
      (scp == SAMP && $past(scp) != SAMP) |-> $stable(sdata));

   // R9: shift clock rests at idle during the latch pulse
   a_r9_scp_idle_in_lp: assert property (@(posedge clk) disable iff (!rst_n)
      lp |-> (scp == SCP_IDLE));

endmodule

bind lcd_row_scan lcd_row_scan_chk #(
   .ROWS(ROWS), .BYTES(BYTES), .SCP_IDLE(SCP_IDLE), .CPHA(CPHA), .AW(AW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .lp(lp), .flm(flm), .scp(scp),
   .sdata(sdata), .fb_rd_en(fb_rd_en), .fb_rd_addr(fb_rd_addr)
);

// File: tb/lcd_row_scan_test.sv
module lcd_scan_monitor #(
   parameter string TAG       = "A",
   parameter int    ROWS      = 4,
   parameter int    BYTES     = 5,
   parameter bit    SCP_IDLE  = 1'b0,
   parameter bit    CPHA      = 1'b0,
   parameter int    FLM_DLY   = 3,
   parameter int    LP_PERIOD = 120,
   parameter int    LP_WIDTH  = 6,
   parameter int    LINES     = 10,
   parameter int    AW        = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          lp,
   input  logic          flm,
   input  logic          scp,
   input  logic          sdata,
   input  logic          rd_en,
   input  logic [AW-1:0] rd_addr,
   output logic [7:0]    rd_data,
   output int            n_checks,
   output int            n_errs,
   output logic          done
);
   localparam int BITS = BYTES * 8;
   localparam bit SAMP = CPHA ? SCP_IDLE : ~SCP_IDLE;

   function automatic logic [7:0] pat(input int a);
      return 8'((a * 37 + 91) & 255);
   endfunction

   function automatic longint row_bits(input int row);
      longint e = 0;
      for (int b = 0; b < BYTES; b++) e = (e << 8) | longint'(pat(row * BYTES + b));
      return e;
   endfunction

   always_ff @(posedge clk) if (rd_en) rd_data <= pat(int'(rd_addr));

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_errs++;
         $display("FAIL %s %s %s: actual %0h expected %0h", TAG, req, what, act, exp);
      end
   endtask

   initial begin
      int     cyc = 0, rise_cyc = 0, fall_cyc = 0, rises = 0, falls = 0;
      int     bcnt = 0, acnt = 0, lines = 0, cur_row = 0;
      longint sh = 0;
      bit     prev_lp = 0, prev_scp = SCP_IDLE, prev_sd = 0, watch = 0;
      bit     flm_old = 0, flm_new = 0;
      n_checks = 0; n_errs = 0; done = 0;
      @(posedge rst_n);
      forever begin
         @(negedge clk);
         cyc++;
         if (scp == SAMP && prev_scp != SAMP) begin
            chk(sdata == prev_sd, "R9", "data moved on sampling edge", sdata, prev_sd);
            sh = (sh << 1) | longint'(sdata);
            bcnt++;
         end
         if (rd_en) begin
            chk(int'(rd_addr) == cur_row * BYTES + acnt, "R8", "read address",
                rd_addr, cur_row * BYTES + acnt);
            acnt++;
         end
         if (lp && !prev_lp) begin
            if (rises > 0) chk(cyc - rise_cyc == LP_PERIOD, "R1", "lp period", cyc - rise_cyc, LP_PERIOD);
            chk(scp == SCP_IDLE, "R9", "scp idle at latch", scp, SCP_IDLE);
            if (falls > 0) begin
               chk(bcnt == BITS, "R5", "bits in line", bcnt, BITS);
               chk(sh == row_bits(cur_row), "R4", "row content", sh, row_bits(cur_row));
               chk(acnt == BYTES, "R8", "reads in line", acnt, BYTES);
               chk(flm == (cur_row == 0), "R6", "flm held to latch", flm, cur_row == 0);
               lines++;
               if (lines == LINES) done = 1;
            end
            rise_cyc = cyc;
            rises++;
         end
         if (!lp && prev_lp) begin
            chk(cyc - rise_cyc == LP_WIDTH, "R2", "lp width", cyc - rise_cyc, LP_WIDTH);
            flm_old  = (falls > 0) && (cur_row == 0);
            cur_row  = falls % ROWS;
            flm_new  = (cur_row == 0);
            falls++;
            fall_cyc = cyc;
            watch    = 1;
            bcnt = 0; acnt = 0; sh = 0;
         end
         if (watch) begin
            if (cyc - fall_cyc == FLM_DLY)
               chk(flm == flm_old, "R7", "flm before delay end", flm, flm_old);
            if (cyc - fall_cyc == FLM_DLY + 1) begin
               chk(flm == flm_new, "R7", "flm after delay", flm, flm_new);
               watch = 0;
            end
         end
         prev_lp = lp; prev_scp = scp; prev_sd = sdata;
      end
   end
endmodule

module lcd_row_scan_test;
   logic clk = 0;
   logic rst_n = 0;
   logic ref_a, ref_b = 0;
   always #5 clk = ~clk;
   assign ref_a = rst_n;
   initial forever begin
      @(negedge clk);
      ref_b = rst_n ? ~ref_b : 1'b0;
   end

   logic       lp_a, flm_a, scp_a, sd_a, re_a, done_a;
   logic [4:0] ad_a;
   logic [7:0] rd_a;
   logic       lp_b, flm_b, scp_b, sd_b, re_b, done_b;
   logic [3:0] ad_b;
   logic [7:0] rd_b;
   int         ck_a, er_a, ck_b, er_b;

   lcd_row_scan #(.PRE1(2), .PRE2(3), .LINE_TICKS(20), .ROWS(4), .BYTES(5),
      .SCP_HALF(1), .SCP_IDLE(1'b0), .CPHA(1'b0), .FLM_DLY(3)) uut (
      .clk(clk), .rst_n(rst_n), .ref_en(ref_a), .fb_rd_data(rd_a),
      .lp(lp_a), .flm(flm_a), .scp(scp_a), .sdata(sd_a),
      .fb_rd_en(re_a), .fb_rd_addr(ad_a));

   lcd_row_scan #(.PRE1(1), .PRE2(4), .LINE_TICKS(30), .ROWS(3), .BYTES(3),
      .SCP_HALF(2), .SCP_IDLE(1'b1), .CPHA(1'b1), .FLM_DLY(2)) uut_b (
      .clk(clk), .rst_n(rst_n), .ref_en(ref_b), .fb_rd_data(rd_b),
      .lp(lp_b), .flm(flm_b), .scp(scp_b), .sdata(sd_b),
      .fb_rd_en(re_b), .fb_rd_addr(ad_b));

   lcd_scan_monitor #(.TAG("A"), .ROWS(4), .BYTES(5), .SCP_IDLE(1'b0), .CPHA(1'b0),
      .FLM_DLY(3), .LP_PERIOD(120), .LP_WIDTH(6), .LINES(10), .AW(5)) m_a (
      .clk(clk), .rst_n(rst_n), .lp(lp_a), .flm(flm_a), .scp(scp_a), .sdata(sd_a),
      .rd_en(re_a), .rd_addr(ad_a), .rd_data(rd_a), .n_checks(ck_a), .n_errs(er_a),
      .done(done_a));

   lcd_scan_monitor #(.TAG("B"), .ROWS(3), .BYTES(3), .SCP_IDLE(1'b1), .CPHA(1'b1),
      .FLM_DLY(2), .LP_PERIOD(240), .LP_WIDTH(8), .LINES(8), .AW(4)) m_b (
      .clk(clk), .rst_n(rst_n), .lp(lp_b), .flm(flm_b), .scp(scp_b), .sdata(sd_b),
      .rd_en(re_b), .rd_addr(ad_b), .rd_data(rd_b), .n_checks(ck_b), .n_errs(er_b),
      .done(done_b));

   int checks = 0, errors = 0;

   task automatic rchk(input bit ok, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL R3 %s: actual %0h expected %0h", what, act, exp);
      end
   endtask

   initial begin
      int cyc = 0;
      repeat (3) @(negedge clk);
      // R3: reset state on both configurations
      rchk(lp_a == 0 && lp_b == 0, "lp in reset", {lp_a, lp_b}, 0);
      rchk(flm_a == 0 && flm_b == 0, "flm in reset", {flm_a, flm_b}, 0);
      rchk(sd_a == 0 && sd_b == 0, "sdata in reset", {sd_a, sd_b}, 0);
      rchk(re_a == 0 && re_b == 0, "read strobe in reset", {re_a, re_b}, 0);
      rchk(scp_a == 0 && scp_b == 1, "scp idle level in reset", {scp_a, scp_b}, 1);
      rst_n = 1;
      while (!(done_a && done_b) && cyc < 20000) begin
         @(negedge clk);
         cyc++;
      end
      if (!(done_a && done_b)) begin
         errors++;
         $display("FAIL watchdog: actual %0d expected done", cyc);
      end
      checks += ck_a + ck_b;
      errors += er_a + er_b;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule